// File: doc/BRIEF.md
# Timestamped Event Cluster Packer

This block sits between the capture front end of a logic analyser and its sample memory. On every event slot (one slot per 20 ns, marked by a one-cycle `tick_i` pulse) it takes one word of raw channel sub-samples. It folds that word into an event word according to the sample-rate mode, and gathers seven events into a cluster behind a 16-bit slot timestamp. Each finished cluster goes out as 16 bytes, low byte first, with markers for the cluster's first and last byte and for the end of each 64-cluster chunk.

The sample-rate mode decides how the raw word is read. The raw word always carries `EVT_W` sub-samples. At the base rate these are one sample from each of 16 channels. At double rate they are two sub-samples from each of 8 channels, and at quadruple rate four sub-samples from each of 4 channels.

A full cluster whose seven events all repeat the last event of the previously written cluster is not stored. The timestamp keeps counting through it, so memory only grows while the inputs change. A reader that sees two timestamps further apart than seven slots repeats the last value across the gap.

When capture stops, a partly filled cluster is completed by repeating its last accepted event. The number of clusters written is exported as a write position, and a done flag rises once the final byte has left.

Top module: `evt_cluster_pack`

## Requirements
- R1: Each cluster is 16 bytes on `out_byte_o`: timestamp low byte, timestamp high byte, then events 0 to 6, each low byte first. `out_head_o` marks only byte 0 and `out_tail_o` marks only byte 15.
- R2: A cluster's timestamp is the slot number of its first event, where the first accepted event after capture start is slot 0 and every accepted event advances the count by one, modulo 2^16.
- R3: With `mode_i` = 0 (one sample, 16 channels), event bit l equals raw bit l.
- R4: With `mode_i` = 1 (two sub-samples, 8 channels), raw bit k*8+l lands in event bit l*2+k.
- R5: With `mode_i` = 2 (four sub-samples, 4 channels), raw bit k*4+l lands in event bit l*4+k. `mode_i` = 3 folds as mode 0.
- R6: A full cluster whose seven events all equal the last event of the previously written cluster of the same capture is not written. Its slots still count toward later timestamps.
- R7: On stop, a cluster holding 1 to 6 events is written with its empty slots filled with the last accepted event. A stop with no events held writes nothing further.
- R8: `done_o` is low during capture, rises after stop once the last byte has been output, and clears on the next capture start.
- R9: `wr_pos_o` counts clusters written since capture start. The low 6 bits are the cluster within the chunk and the upper bits are the chunk index. `out_chunk_end_o` marks byte 15 of every cluster with in-chunk index 63.
- R10: `tick_i` pulses while `cap_en_i` is low produce no output and change neither the write position nor the done flag.
- R11: A new capture start (rising `cap_en_i` while idle or done) restarts the timestamp at slot 0 and the write position at 0.
- R12: After reset, `out_valid_o`, `done_o` and `wr_pos_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en_i | input | 1 | Capture enable; rising starts, falling stops |
| tick_i | input | 1 | One-cycle pulse per event slot |
| mode_i | input | 2 | Fold mode: 0 = 16x1, 1 = 8x2, 2 = 4x4, 3 = as 0 |
| raw_i | input | EVT_W | Raw sub-samples, sub-sample k of channel l at bit k*channels+l |
| out_valid_o | output | 1 | A cluster byte is present |
| out_byte_o | output | 8 | Cluster byte |
| out_head_o | output | 1 | First byte of a cluster |
| out_tail_o | output | 1 | Last byte of a cluster |
| out_chunk_end_o | output | 1 | Last byte of the last cluster of a chunk |
| wr_pos_o | output | POS_W | Clusters written: chunk index and cluster index |
| done_o | output | 1 | Capture stopped and all bytes output |

## Verification
The checks on the output stream assume that slot pulses arrive at least three clocks apart. At that spacing a cluster's 16 bytes drain before the next seven slots complete another cluster, so a finished cluster never finds the serializer busy. The checks also assume that `mode_i` holds steady for a whole capture. The directed stimulus spaces every slot pulse four clocks apart and changes the mode only between captures, with `cap_en_i` low. It also drives slot pulses while capture is off, to show they are ignored.

// File: rtl/evpk_pkg.sv
package evpk_pkg;
   typedef enum logic [1:0] {
      FOLD_X1  = 2'd0,
      FOLD_X2  = 2'd1,
      FOLD_X4  = 2'd2,
      FOLD_RSV = 2'd3
   } fold_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FLUSH = 2'd2,
      ST_DONE  = 2'd3
   } run_e;
endpackage

// File: rtl/evpk_fold.sv
module evpk_fold
   import evpk_pkg::*;
#(
   parameter int EVT_W = 16
) (
   input  logic [EVT_W-1:0] raw_i,
   input  fold_e            mode_i,
   output logic [EVT_W-1:0] evt_o
);
   localparam int NVAR = 3;

   // one fold variant per sub-sample count 1, 2, 4
   for (genvar v = 0; v < NVAR; v++) begin : g_var
      localparam int SPE = 1 << v;
      localparam int CH  = EVT_W / SPE;
      logic [EVT_W-1:0] w;
      for (genvar l = 0; l < CH; l++) begin : g_ch
         for (genvar k = 0; k < SPE; k++) begin : g_sub
            assign w[l*SPE+k] = raw_i[k*CH+l];
         end
      end
   end

   always_comb begin
      case (mode_i)
         FOLD_X2: evt_o = g_var[1].w;
         FOLD_X4: evt_o = g_var[2].w;
         default: evt_o = g_var[0].w;
      endcase
   end
endmodule

// File: rtl/evpk_gather.sv
module evpk_gather
   import evpk_pkg::*;
#(
   parameter int EVT_W       = 16,
   parameter int EPC         = 7,
   parameter bit SKIP_REPEAT = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cap_en_i,
   input  logic                        tick_i,
   input  logic [EVT_W-1:0]            evt_i,
   input  logic                        ser_busy_i,
   output logic                        start_o,
   output logic                        push_o,
   output logic [EVT_W-1:0]            push_ts_o,
   output logic [EPC-1:0][EVT_W-1:0]   push_evts_o,
   output run_e                        state_o
);
   localparam int FILL_W = $clog2(EPC);
   localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(EPC-1);

   run_e                      state_q;
   logic [FILL_W-1:0]         fill_q;
   logic [EPC-1:0][EVT_W-1:0] ebuf_q;
   logic [EVT_W-1:0]          slot_q;
   logic [EVT_W-1:0]          cl_ts_q;
   logic [EVT_W-1:0]          last_q;
   logic [EVT_W-1:0]          prev_q;
   logic                      have_prev_q;

   logic                      accept_w;
   logic                      full_w;
   logic                      flush_w;
   logic                      same_w;
   logic [EPC-1:0][EVT_W-1:0] asm_w;

   assign start_o  = cap_en_i && (state_q == ST_IDLE || state_q == ST_DONE);
   assign accept_w = (state_q == ST_RUN) && cap_en_i && tick_i;
   assign full_w   = accept_w && (fill_q == FILL_LAST);
   assign flush_w  = (state_q == ST_FLUSH) && !ser_busy_i;

   // cluster as it would be stored: full (current event last) or padded
   always_comb begin
      for (int j = 0; j < EPC; j++) begin
         if (state_q == ST_FLUSH)
            asm_w[j] = (FILL_W'(j) < fill_q) ? ebuf_q[j] : last_q;
         else
            asm_w[j] = (j == EPC-1) ? evt_i : ebuf_q[j];
      end
   end

   if (SKIP_REPEAT) begin : g_skip
      logic [EPC-1:0] eq_w;
      for (genvar j = 0; j < EPC; j++) begin : g_eq
         assign eq_w[j] = (asm_w[j] == prev_q);
      end
      assign same_w = have_prev_q && (&eq_w);
   end else begin : g_keep
      assign same_w = 1'b0;
   end

   assign push_o      = (full_w && !same_w) || flush_w;
   assign push_ts_o   = cl_ts_q;
   assign push_evts_o = asm_w;
   assign state_o     = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         fill_q      <= '0;
         ebuf_q      <= '0;
         slot_q      <= '0;
         cl_ts_q     <= '0;
         last_q      <= '0;
         prev_q      <= '0;
         have_prev_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (cap_en_i) begin
                  state_q     <= ST_RUN;
                  fill_q      <= '0;
                  slot_q      <= '0;
                  have_prev_q <= 1'b0;
               end
            end
            ST_RUN: begin
               if (!cap_en_i) begin
                  state_q <= (fill_q != '0) ? ST_FLUSH : ST_DONE;
               end else if (tick_i) begin
                  ebuf_q[fill_q] <= evt_i;
                  last_q         <= evt_i;
                  slot_q         <= slot_q + 1'b1;
                  if (fill_q == '0)
                     cl_ts_q <= slot_q;
                  if (full_w) begin
                     fill_q <= '0;
                     if (!same_w) begin
                        prev_q      <= evt_i;
                        have_prev_q <= 1'b1;
                     end
                  end else begin
                     fill_q <= fill_q + 1'b1;
                  end
               end
            end
            ST_FLUSH: begin
               if (!ser_busy_i) begin
                  state_q <= ST_DONE;
                  fill_q  <= '0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/evpk_serial.sv
module evpk_serial #(
   parameter  int EVT_W   = 16,
   parameter  int EPC     = 7,
   parameter  int CPC     = 64,
   parameter  int CHUNK_W = 10,
   localparam int POS_W   = $clog2(CPC) + CHUNK_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear_i,
   input  logic                      load_i,
   input  logic [EVT_W-1:0]          ts_i,
   input  logic [EPC-1:0][EVT_W-1:0] evts_i,
   output logic                      busy_o,
   output logic [7:0]                byte_o,
   output logic                      head_o,
   output logic                      tail_o,
   output logic                      chunk_end_o,
   output logic [POS_W-1:0]          pos_o
);
   localparam int FLAT_W = (EPC + 1) * EVT_W;
   localparam int NBYTES = FLAT_W / 8;
   localparam int CNT_W  = $clog2(NBYTES);
   localparam int CL_W   = $clog2(CPC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBYTES-1);
   localparam logic [CL_W-1:0]  CL_LAST  = CL_W'(CPC-1);

   logic [FLAT_W-1:0] flat_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;
   logic [POS_W-1:0]  pos_q;
   logic [CL_W-1:0]   cl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flat_q <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         pos_q  <= '0;
         cl_q   <= '0;
      end else begin
         if (clear_i)
            pos_q <= '0;
         if (load_i) begin
            flat_q <= {evts_i, ts_i};
            cnt_q  <= '0;
            busy_q <= 1'b1;
            pos_q  <= pos_q + 1'b1;
            cl_q   <= pos_q[CL_W-1:0];
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST)
               busy_q <= 1'b0;
         end
      end
   end

   assign busy_o      = busy_q;
   assign byte_o      = flat_q[{cnt_q, 3'b000} +: 8];
   assign head_o      = busy_q && (cnt_q == '0);
   assign tail_o      = busy_q && (cnt_q == CNT_LAST);
   assign chunk_end_o = tail_o && (cl_q == CL_LAST);
   assign pos_o       = pos_q;
endmodule

// File: rtl/evt_cluster_pack.sv
module evt_cluster_pack
   import evpk_pkg::*;
#(
   parameter  int EVT_W       = 16,
   parameter  int EPC         = 7,
   parameter  int CPC         = 64,
   parameter  int CHUNK_W     = 10,
   parameter  bit SKIP_REPEAT = 1'b1,
   localparam int POS_W       = $clog2(CPC) + CHUNK_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en_i,
   input  logic             tick_i,
   input  logic [1:0]       mode_i,
   input  logic [EVT_W-1:0] raw_i,
   output logic             out_valid_o,
   output logic [7:0]       out_byte_o,
   output logic             out_head_o,
   output logic             out_tail_o,
   output logic             out_chunk_end_o,
   output logic [POS_W-1:0] wr_pos_o,
   output logic             done_o
);
   if (EVT_W < 8 || (EVT_W % 8) != 0) begin : g_bad_width
      $error("EVT_W must be a positive multiple of 8");
   end
   if (EPC < 2) begin : g_bad_epc
      $error("EPC must be at least 2");
   end
   if (CPC < 2 || (CPC & (CPC - 1)) != 0) begin : g_bad_cpc
      $error("CPC must be a power of two");
   end

   logic [EVT_W-1:0]          evt_w;
   logic                      start_w;
   logic                      push_w;
   logic                      busy_w;
   logic [EVT_W-1:0]          push_ts_w;
   logic [EPC-1:0][EVT_W-1:0] push_evts_w;
   run_e                      state_w;

   evpk_fold #(.EVT_W(EVT_W)) u_fold (
      .raw_i  (raw_i),
      .mode_i (fold_e'(mode_i)),
      .evt_o  (evt_w)
   );

   evpk_gather #(
      .EVT_W       (EVT_W),
      .EPC         (EPC),
      .SKIP_REPEAT (SKIP_REPEAT)
   ) u_gather (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_en_i    (cap_en_i),
      .tick_i      (tick_i),
      .evt_i       (evt_w),
      .ser_busy_i  (busy_w),
      .start_o     (start_w),
      .push_o      (push_w),
      .push_ts_o   (push_ts_w),
      .push_evts_o (push_evts_w),
      .state_o     (state_w)
   );

   evpk_serial #(
      .EVT_W   (EVT_W),
      .EPC     (EPC),
      .CPC     (CPC),
      .CHUNK_W (CHUNK_W)
   ) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (start_w),
      .load_i      (push_w),
      .ts_i        (push_ts_w),
      .evts_i      (push_evts_w),
      .busy_o      (busy_w),
      .byte_o      (out_byte_o),
      .head_o      (out_head_o),
      .tail_o      (out_tail_o),
      .chunk_end_o (out_chunk_end_o),
      .pos_o       (wr_pos_o)
   );

   assign out_valid_o = busy_w;
   assign done_o      = (state_w == ST_DONE) && !busy_w;
endmodule

// File: rtl/evpk_chk.sv
module evpk_chk #(
   parameter int POS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid_i,
   input logic             out_head_i,
   input logic             out_tail_i,
   input logic             out_chunk_end_i,
   input logic             done_i,
   input logic [POS_W-1:0] wr_pos_i,
   input logic             push_i,
   input logic             busy_i
);
   // R1: a started cluster keeps streaming without a second head
   a_r1_head_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_i && out_head_i && !out_tail_i) |=> (out_valid_i && !out_head_i));

   // R1: a finished cluster never arrives while bytes are still leaving
   a_r1_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !busy_i);

   // R8: done only once the stream is quiet
   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> !out_valid_i);

   // R9: position steps by one, together with a new cluster head
   a_r9_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pos_i != $past(wr_pos_i) && wr_pos_i != '0)
      |-> (wr_pos_i == $past(wr_pos_i) + 1'b1) && out_head_i && out_valid_i);

   // R9: chunk end only on a cluster's last byte
   a_r9_chunk_on_tail: assert property (@(posedge clk) disable iff (!rst_n)
      out_chunk_end_i |-> (out_tail_i && out_valid_i));
endmodule

bind evt_cluster_pack evpk_chk #(.POS_W(POS_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .out_valid_i     (out_valid_o),
   .out_head_i      (out_head_o),
   .out_tail_i      (out_tail_o),
   .out_chunk_end_i (out_chunk_end_o),
   .done_i          (done_o),
   .wr_pos_i        (wr_pos_o),
   .push_i          (push_w),
   .busy_i          (busy_w)
);

// File: tb/evt_cluster_pack_tb_top.sv
`timescale 1ns/1ps
module evt_cluster_pack_tb_top;
   localparam int POS_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cap_en = 1'b0;
   logic             tick = 1'b0;
   logic [1:0]       mode = 2'd0;
   logic [15:0]      raw = '0;
   logic             out_valid;
   logic [7:0]       out_byte;
   logic             out_head;
   logic             out_tail;
   logic             out_chunk_end;
   logic [POS_W-1:0] wr_pos;
   logic             done;

   int n_chk = 0;
   int n_err = 0;

   logic [7:0] cap_b[$];
   bit         cap_h[$];
   bit         cap_t[$];
   bit         cap_c[$];

   always #2.5 clk = ~clk;

   evt_cluster_pack dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .cap_en_i        (cap_en),
      .tick_i          (tick),
      .mode_i          (mode),
      .raw_i           (raw),
      .out_valid_o     (out_valid),
      .out_byte_o      (out_byte),
      .out_head_o      (out_head),
      .out_tail_o      (out_tail),
      .out_chunk_end_o (out_chunk_end),
      .wr_pos_o        (wr_pos),
      .done_o          (done)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         cap_b.push_back(out_byte);
         cap_h.push_back(out_head);
         cap_t.push_back(out_tail);
         cap_c.push_back(out_chunk_end);
      end
   end

   task automatic chk_eq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] fold_ref(input logic [15:0] r, input int m);
      logic [15:0] e;
      int spe;
      int ch;
      spe = (m == 1) ? 2 : (m == 2) ? 4 : 1;
      ch  = 16 / spe;
      e   = '0;
      for (int l = 0; l < ch; l++)
         for (int k = 0; k < spe; k++)
            e[l*spe+k] = r[k*ch+l];
      return e;
   endfunction

   function automatic logic [15:0] word_at(input int byte_idx);
      return {cap_b[byte_idx+1], cap_b[byte_idx]};
   endfunction

   function automatic int count_set(input int which);
      int n;
      n = 0;
      for (int i = 0; i < cap_b.size(); i++) begin
         if (which == 0 && cap_h[i]) n++;
         if (which == 1 && cap_t[i]) n++;
         if (which == 2 && cap_c[i]) n++;
      end
      return n;
   endfunction

   task automatic clear_cap();
      cap_b.delete();
      cap_h.delete();
      cap_t.delete();
      cap_c.delete();
   endtask

   task automatic begin_cap(input logic [1:0] m);
      @(negedge clk);
      mode   = m;
      cap_en = 1'b1;
      clear_cap();
      @(negedge clk);
   endtask

   task automatic send_evt(input logic [15:0] r);
      @(negedge clk);
      raw  = r;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic end_cap();
      @(negedge clk);
      cap_en = 1'b0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (done) break;
      end
   endtask

   task automatic t_reset();
      chk_eq("R12", "valid after reset", 32'(out_valid), 0);
      chk_eq("R12", "done after reset", 32'(done), 0);
      chk_eq("R12", "pos after reset", 32'(wr_pos), 0);
   endtask

   task automatic t_base();
      logic [15:0] v[14];
      begin_cap(2'd0);
      for (int i = 0; i < 14; i++) begin
         v[i] = 16'hA5C3 ^ (16'(i) * 16'h1357);
         send_evt(v[i]);
      end
      chk_eq("R8", "done during capture", 32'(done), 0);
      end_cap();
      chk_eq("R1", "byte count two clusters", cap_b.size(), 32);
      chk_eq("R1", "head count", count_set(0), 2);
      chk_eq("R1", "tail count", count_set(1), 2);
      chk_eq("R1", "head on byte 16", 32'(cap_h[16]), 1);
      chk_eq("R1", "tail on byte 31", 32'(cap_t[31]), 1);
      chk_eq("R2", "ts cluster 0", word_at(0), 0);
      chk_eq("R2", "ts cluster 1", word_at(16), 7);
      for (int c = 0; c < 2; c++)
         for (int j = 0; j < 7; j++)
            chk_eq("R3", "mode 0 event", word_at(c*16 + 2 + 2*j), v[c*7+j]);
      chk_eq("R8", "done after stop", 32'(done), 1);
      chk_eq("R9", "pos after two clusters", 32'(wr_pos), 2);
   endtask

   task automatic t_fold(input logic [1:0] m, input string req);
      logic [15:0] v[7];
      int rm;
      rm = (m == 2'd3) ? 0 : int'(m);
      begin_cap(m);
      for (int i = 0; i < 7; i++) begin
         v[i] = 16'h0001 << (i * 2) ^ (16'h8421 >> i) ^ 16'h3C00;
         send_evt(v[i]);
      end
      end_cap();
      chk_eq(req, "fold byte count", cap_b.size(), 16);
      for (int j = 0; j < 7; j++)
         chk_eq(req, "folded event", word_at(2 + 2*j), fold_ref(v[j], rm));
   endtask

   task automatic t_pad();
      logic [15:0] v[10];
      begin_cap(2'd0);
      for (int i = 0; i < 10; i++) begin
         v[i] = 16'h7000 + 16'(i) * 16'h0101;
         send_evt(v[i]);
      end
      end_cap();
      chk_eq("R7", "padded byte count", cap_b.size(), 32);
      chk_eq("R7", "padded ts", word_at(16), 7);
      for (int j = 0; j < 7; j++)
         chk_eq("R7", "padded event", word_at(16 + 2 + 2*j), (j < 3) ? v[7+j] : v[9]);
      chk_eq("R7", "padded pos", 32'(wr_pos), 2);
      chk_eq("R8", "done after padding", 32'(done), 1);
   endtask

   task automatic t_exact();
      begin_cap(2'd0);
      for (int i = 0; i < 7; i++) send_evt(16'h0F00 + 16'(i));
      end_cap();
      chk_eq("R7", "no extra cluster on empty stop", cap_b.size(), 16);
      chk_eq("R7", "pos on empty stop", 32'(wr_pos), 1);
   endtask

   task automatic t_ignore();
      int n0;
      logic [POS_W-1:0] p0;
      n0 = cap_b.size();
      p0 = wr_pos;
      for (int i = 0; i < 3; i++) send_evt(16'hDEAD + 16'(i));
      chk_eq("R10", "bytes while disabled", cap_b.size(), n0);
      chk_eq("R10", "pos while disabled", 32'(wr_pos), 32'(p0));
      chk_eq("R10", "done while disabled", 32'(done), 1);
   endtask

   task automatic t_skip();
      logic [15:0] c[7];
      begin_cap(2'd0);
      for (int i = 0; i < 14; i++) send_evt(16'h5A5A);
      chk_eq("R6", "repeat cluster dropped", cap_b.size(), 16);
      for (int i = 0; i < 7; i++) begin
         c[i] = 16'h1100 + 16'(i);
         send_evt(c[i]);
      end
      end_cap();
      chk_eq("R6", "byte count with skip", cap_b.size(), 32);
      chk_eq("R6", "ts after skipped cluster", word_at(16), 14);
      chk_eq("R6", "first event after skip", word_at(18), c[0]);
      chk_eq("R6", "pos with skip", 32'(wr_pos), 2);
   endtask

   task automatic t_restart();
      chk_eq("R8", "done before restart", 32'(done), 1);
      @(negedge clk);
      cap_en = 1'b1;
      clear_cap();
      @(negedge clk);
      chk_eq("R8", "done cleared on start", 32'(done), 0);
      chk_eq("R11", "pos cleared on start", 32'(wr_pos), 0);
      for (int i = 0; i < 7; i++) send_evt(16'h2200 + 16'(i));
      end_cap();
      chk_eq("R11", "ts restarts at 0", word_at(0), 0);
      chk_eq("R11", "pos after restart", 32'(wr_pos), 1);
   endtask

   task automatic t_chunk();
      begin_cap(2'd0);
      for (int i = 0; i < 448; i++) send_evt(16'(i + 1));
      end_cap();
      chk_eq("R9", "chunk byte count", cap_b.size(), 1024);
      chk_eq("R9", "chunk end count", count_set(2), 1);
      chk_eq("R9", "chunk end on final byte", 32'(cap_c[1023]), 1);
      chk_eq("R9", "pos after one chunk", 32'(wr_pos), 64);
      chk_eq("R2", "ts of cluster 63", word_at(63*16), 441);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_base();
      t_fold(2'd1, "R4");
      t_fold(2'd2, "R5");
      t_fold(2'd3, "R5");
      t_pad();
      t_exact();
      t_ignore();
      t_skip();
      t_restart();
      t_chunk();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule